// File: doc/BRIEF.md
# Image Encoder Host Register Slave

This block is the host-facing register slave of an image compression engine. It sits on a 32-bit on-chip peripheral bus. A transfer has a select, an address, a read-not-write flag, four byte enables and a one-cycle transfer acknowledge. Software uses it to program the frame geometry and the number of colour components, and to load a 64-entry quantization table. It then launches a frame and polls a status word until the engine reports completion.

The core side receives the frame width, height and component count as steady outputs. It also receives a one-cycle frame start pulse and a byte-wide table write port that fires while the bus write is being acknowledged. A done pulse comes back from the core. The block turns it into a status code that software can read.

Top module: `enc_host_regs`

## Requirements
- R1: While reset is asserted and directly after it, `bus_ack`, `core_start` and `qt_we` are low. The control, size and status words read back as zero.
- R2: The slave raises `bus_ack` exactly one cycle after it first samples `bus_sel` high. The acknowledge lasts one cycle and is not repeated until `bus_sel` has been sampled low.
- R3: `bus_rdata` is zero whenever `bus_ack` is low. Any address that is not one of the mapped words (including addresses with bits 1:0 not zero) is still acknowledged. It reads as zero, and writing it changes no register and fires no table write.
- R4: The control word is at address 0x00. Bits 3:1 hold the component count, which drives `core_ncomp`. Bit 0 always reads back as 0.
- R5: A control write with bit 0 set raises `core_start` for exactly one cycle, the cycle after the acknowledge. The status becomes busy (value 1) at the same time. A control write with bit 0 clear gives no pulse and leaves the status unchanged.
- R6: The status word is at address 0x0C and uses the codes 0 idle, 1 busy and 2 done, zero-extended. A `core_done` pulse while busy moves the status to 2. A `core_done` pulse in idle or done has no effect.
- R7: The size word is at address 0x04. Width is in bits 31:16 and height in bits 15:0. It reads back and drives `core_width` and `core_height`.
- R8: Table entry i is at address 0x100 + 4*i (i = 0..63). A write drives `qt_we`=1, `qt_waddr`=i and `qt_wdata`=bits 7:0 of the write data during the acknowledge cycle. A read returns the stored byte zero-extended.
- R9: Writes honour byte enables. `bus_be[k]` gates bits 8k+7:8k of the size word. `bus_be[0]` gates the control write, its start command and a table write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Transfer select, held until acknowledged |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 32 | Byte address |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | Transfer acknowledge |
| core_start | output | 1 | One-cycle frame start |
| core_ncomp | output | 3 | Component count |
| core_width | output | 16 | Frame width |
| core_height | output | 16 | Frame height |
| qt_we | output | 1 | Table write enable |
| qt_waddr | output | 6 | Table entry index |
| qt_wdata | output | 8 | Table entry value |
| core_done | input | 1 | Frame finished pulse from the core |

## Verification
The acknowledge is due one cycle after select is first sampled, and read data and the table write port are valid in that cycle. Register contents, the start pulse and the status update appear one cycle later, after the edge that closes the acknowledge. The bench drives every transfer on falling edges. It samples acknowledge, read data and the table port at the falling edge inside the acknowledge cycle. It samples the start pulse at the next falling edge and checks that it is gone one cycle after that. A done pulse is applied for one full cycle, and the status is observed by a bus read issued afterwards.

// File: rtl/enc_host_pkg.sv
`timescale 1ns/1ps
package enc_host_pkg;

   typedef enum logic [1:0] {
      FST_IDLE = 2'd0,
      FST_BUSY = 2'd1,
      FST_DONE = 2'd2
   } frame_st_t;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/ehr_bus_ack.sv
`timescale 1ns/1ps
module ehr_bus_ack (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   output logic ack
);
   logic ack_q;
   logic served_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q    <= 1'b0;
         served_q <= 1'b0;
      end else begin
         ack_q    <= sel & ~ack_q & ~served_q;
         served_q <= sel & (served_q | ack_q);
      end
   end

   assign ack = ack_q;

   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |=> !ack_q); // R2
   AST_ACK_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |-> $past(sel)); // R2

endmodule

// File: rtl/ehr_ctrl_regs.sv
`timescale 1ns/1ps
module ehr_ctrl_regs
   import enc_host_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DIM_W  = 16,
   parameter int unsigned COMP_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_ctrl,
   input  logic                  wr_size,
   input  logic [DATA_W/8-1:0]   be,
   input  logic [DATA_W-1:0]     wdata,
   input  logic                  done_in,
   output logic                  start_out,
   output logic [COMP_W-1:0]     ncomp_out,
   output logic [DIM_W-1:0]      width_out,
   output logic [DIM_W-1:0]      height_out,
   output frame_st_t             status_out
);
   localparam int unsigned NBYTES = DATA_W / BYTE_W;

   logic [DATA_W-1:0] size_q;
   logic [COMP_W-1:0] ncomp_q;
   logic              start_q;
   frame_st_t         st_q;
   logic              ctrl_lane;
   logic              launch;

   assign ctrl_lane = wr_ctrl & be[0];
   assign launch    = ctrl_lane & wdata[0];

   for (genvar b = 0; b < NBYTES; b++) begin : g_size_lane
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            size_q[b*BYTE_W +: BYTE_W] <= '0;
         end else if (wr_size && be[b]) begin
            size_q[b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ncomp_q <= '0;
         start_q <= 1'b0;
         st_q    <= FST_IDLE;
      end else begin
         start_q <= launch;
         if (ctrl_lane) begin
            ncomp_q <= wdata[COMP_W:1];
         end
         if (launch) begin
            st_q <= FST_BUSY;
         end else if (done_in && st_q == FST_BUSY) begin
            st_q <= FST_DONE;
         end
      end
   end

   assign start_out  = start_q;
   assign ncomp_out  = ncomp_q;
   assign width_out  = size_q[DATA_W-1:DIM_W];
   assign height_out = size_q[DIM_W-1:0];
   assign status_out = st_q;

   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q); // R5
   AST_BUSY_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> st_q == FST_BUSY); // R5
   AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      st_q != 2'd3); // R6
   AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FST_DONE && $past(st_q) != FST_DONE) |-> $past(st_q) == FST_BUSY); // R6

endmodule

// File: rtl/ehr_qtab.sv
`timescale 1ns/1ps
module ehr_qtab #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned W     = 8,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/enc_host_regs.sv
`timescale 1ns/1ps
module enc_host_regs
   import enc_host_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned DIM_W    = 16,
   parameter int unsigned COMP_W   = 3,
   parameter int unsigned QT_DEPTH = 64,
   parameter int unsigned QT_W     = 8,
   parameter int unsigned CTRL_OFF = 'h000,
   parameter int unsigned SIZE_OFF = 'h004,
   parameter int unsigned STAT_OFF = 'h00C,
   parameter int unsigned QT_BASE  = 'h100,
   localparam int unsigned QT_AW   = $clog2(QT_DEPTH),
   localparam int unsigned NBYTES  = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_rnw,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [NBYTES-1:0] bus_be,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_ack,
   output logic              core_start,
   output logic [COMP_W-1:0] core_ncomp,
   output logic [DIM_W-1:0]  core_width,
   output logic [DIM_W-1:0]  core_height,
   output logic              qt_we,
   output logic [QT_AW-1:0]  qt_waddr,
   output logic [QT_W-1:0]   qt_wdata,
   input  logic              core_done
);
   localparam int unsigned QT_LG = QT_AW + 2;

   if (DATA_W != 2 * DIM_W) begin : g_bad_dim
      $error("size word must hold exactly two dimensions");
   end
   if (DATA_W % 8 != 0) begin : g_bad_lanes
      $error("data width must be whole bytes");
   end
   if (COMP_W + 1 > 8) begin : g_bad_comp
      $error("control fields must fit byte lane 0");
   end
   if (QT_W > 8) begin : g_bad_qtw
      $error("table entries must fit byte lane 0");
   end
   if ((1 << QT_AW) != QT_DEPTH) begin : g_bad_depth
      $error("table depth must be a power of two");
   end
   if (QT_BASE % (4 * QT_DEPTH) != 0) begin : g_bad_base
      $error("table window must be aligned to its span");
   end

   logic      ack;
   logic      wr;
   logic      rd;
   logic      hit_ctrl, hit_size, hit_stat, hit_qt;
   logic [QT_AW-1:0] qt_idx;
   logic [QT_W-1:0]  qt_rd;
   frame_st_t status;
   logic [DATA_W-1:0] rdata_mux;

   ehr_bus_ack u_ack (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (bus_sel),
      .ack   (ack)
   );

   assign hit_ctrl = (bus_addr == ADDR_W'(CTRL_OFF));
   assign hit_size = (bus_addr == ADDR_W'(SIZE_OFF));
   assign hit_stat = (bus_addr == ADDR_W'(STAT_OFF));
   assign hit_qt   = (bus_addr[1:0] == 2'b00) &&
                     ((bus_addr >> QT_LG) == ADDR_W'(QT_BASE >> QT_LG));
   assign qt_idx   = bus_addr[QT_LG-1:2];

   assign wr = ack & ~bus_rnw;
   assign rd = ack &  bus_rnw;

   ehr_ctrl_regs #(
      .DATA_W (DATA_W),
      .DIM_W  (DIM_W),
      .COMP_W (COMP_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ctrl    (wr & hit_ctrl),
      .wr_size    (wr & hit_size),
      .be         (bus_be),
      .wdata      (bus_wdata),
      .done_in    (core_done),
      .start_out  (core_start),
      .ncomp_out  (core_ncomp),
      .width_out  (core_width),
      .height_out (core_height),
      .status_out (status)
   );

   assign qt_we    = wr & hit_qt & bus_be[0];
   assign qt_waddr = qt_idx;
   assign qt_wdata = bus_wdata[QT_W-1:0];

   ehr_qtab #(
      .DEPTH (QT_DEPTH),
      .W     (QT_W)
   ) u_qtab (
      .clk   (clk),
      .we    (qt_we),
      .waddr (qt_waddr),
      .wdata (qt_wdata),
      .raddr (qt_idx),
      .rdata (qt_rd)
   );

   always_comb begin
      rdata_mux = '0;
      if (rd) begin
         if (hit_ctrl) begin
            rdata_mux = DATA_W'({core_ncomp, 1'b0});
         end else if (hit_size) begin
            rdata_mux = {core_width, core_height};
         end else if (hit_stat) begin
            rdata_mux = DATA_W'(status);
         end else if (hit_qt) begin
            rdata_mux = DATA_W'(qt_rd);
         end
      end
   end

   assign bus_rdata = rdata_mux;
   assign bus_ack   = ack;

   AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ack |-> bus_rdata == '0); // R3
   AST_START_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |-> $past(bus_ack && !bus_rnw && bus_sel)); // R5
   AST_QT_WE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      qt_we |=> !qt_we); // R8

endmodule

// File: tb/enc_host_regs_tb.sv
`timescale 1ns/1ps
module enc_host_regs_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_rnw = 1'b0;
   logic [31:0] bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ack;
   logic        core_start;
   logic [2:0]  core_ncomp;
   logic [15:0] core_width;
   logic [15:0] core_height;
   logic        qt_we;
   logic [5:0]  qt_waddr;
   logic [7:0]  qt_wdata;
   logic        core_done = 1'b0;

   int nvec = 0;
   int nerr = 0;

   logic        o_ack1, o_ack2, o_st1, o_st2, o_st3, o_qwe;
   logic [31:0] o_rd;
   logic [5:0]  o_qa;
   logic [7:0]  o_qd;
   logic [31:0] size_exp;
   logic [7:0]  qexp [64];

   enc_host_regs dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_sel     (bus_sel),
      .bus_rnw     (bus_rnw),
      .bus_addr    (bus_addr),
      .bus_be      (bus_be),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .bus_ack     (bus_ack),
      .core_start  (core_start),
      .core_ncomp  (core_ncomp),
      .core_width  (core_width),
      .core_height (core_height),
      .qt_we       (qt_we),
      .qt_waddr    (qt_waddr),
      .qt_wdata    (qt_wdata),
      .core_done   (core_done)
   );

   always #2 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic access(input logic rnw, input logic [31:0] a,
                         input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      bus_sel = 1'b1; bus_rnw = rnw; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      o_ack1 = bus_ack; o_rd = bus_rdata; o_st1 = core_start;
      o_qwe = qt_we; o_qa = qt_waddr; o_qd = qt_wdata;
      @(negedge clk);
      o_ack2 = bus_ack; o_st2 = core_start;
      bus_sel = 1'b0; bus_rnw = 1'b0; bus_addr = '0; bus_wdata = '0; bus_be = '0;
      @(negedge clk);
      o_st3 = core_start;
      // R2: one acknowledge, one cycle after select
      chk("R2", {30'd0, o_ack1, o_ack2}, 32'd2);
   endtask

   task automatic rd_chk(input string req, input logic [31:0] a, input logic [31:0] exp);
      access(1'b1, a, 32'd0, 4'hF);
      chk(req, o_rd, exp);
   endtask

   task automatic pulse_done();
      @(negedge clk); core_done = 1'b1;
      @(negedge clk); core_done = 1'b0;
   endtask

   function automatic logic [7:0] qv(input int i);
      return 8'((i * 29 + 7) & 255);
   endfunction

   initial begin
      #(4 * 150000);
      nerr++;
      $display("FAIL watchdog actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: quiet outputs during reset
      chk("R1", {29'd0, bus_ack, core_start, qt_we}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {29'd0, bus_ack, core_start, qt_we}, 32'd0);
      rd_chk("R1", 32'h0, 32'd0);
      rd_chk("R1", 32'h4, 32'd0);
      rd_chk("R1", 32'hC, 32'd0);
      chk("R3", bus_rdata, 32'd0);

      // R6: done while idle is ignored
      pulse_done();
      rd_chk("R6", 32'hC, 32'd0);

      // R8: fill and read back the whole table
      for (int i = 0; i < 64; i++) begin
         access(1'b0, 32'h100 + 4 * i, {24'hABCDE0, qv(i)}, 4'hF);
         chk("R8", {23'd0, o_qwe, 2'd0, o_qa}, {23'd0, 1'b1, 2'd0, 6'(i)});
         chk("R8", {24'd0, o_qd}, {24'd0, qv(i)});
         qexp[i] = qv(i);
      end
      for (int i = 0; i < 64; i++) rd_chk("R8", 32'h100 + 4 * i, {24'd0, qexp[i]});

      // R9: table write without lane 0 is dropped
      access(1'b0, 32'h100 + 4 * 5, 32'h0000_00EE, 4'hE);
      chk("R9", {31'd0, o_qwe}, 32'd0);
      rd_chk("R9", 32'h114, {24'd0, qexp[5]});

      // R3: unmapped and misaligned accesses
      access(1'b0, 32'h200, 32'h55, 4'hF);
      chk("R3", {31'd0, o_qwe}, 32'd0);
      access(1'b0, 32'h102, 32'h66, 4'hF);
      chk("R3", {31'd0, o_qwe}, 32'd0);
      rd_chk("R3", 32'h100, {24'd0, qexp[0]});
      rd_chk("R3", 32'h8, 32'd0);
      rd_chk("R3", 32'h10, 32'd0);
      rd_chk("R3", 32'hFC, 32'd0);
      rd_chk("R3", 32'h200, 32'd0);
      rd_chk("R3", 32'h6, 32'd0);

      // R7: full size write
      size_exp = 32'h0040_0030;
      access(1'b0, 32'h4, size_exp, 4'hF);
      rd_chk("R7", 32'h4, size_exp);
      chk("R7", {core_width, core_height}, size_exp);

      // R9: sweep all byte-enable patterns on the size word
      for (int be = 0; be < 16; be++) begin
         logic [31:0] v;
         v = 32'h0101_0101 * 32'(be + 3) ^ 32'hC3A5_5A3C;
         access(1'b0, 32'h4, v, 4'(be));
         for (int b = 0; b < 4; b++)
            if (be[b]) size_exp[b*8 +: 8] = v[b*8 +: 8];
         rd_chk("R9", 32'h4, size_exp);
         chk("R7", {core_width, core_height}, size_exp);
      end

      // R3: write to unmapped word leaves size and control alone
      access(1'b0, 32'h8, 32'hFFFF_FFFF, 4'hF);
      rd_chk("R3", 32'h4, size_exp);
      rd_chk("R3", 32'h0, 32'd0);

      // R4: component count sweep without start
      for (int n = 0; n < 8; n++) begin
         access(1'b0, 32'h0, 32'(n << 1), 4'hF);
         chk("R5", {29'd0, o_st1, o_st2, o_st3}, 32'd0);
         rd_chk("R4", 32'h0, 32'(n << 1));
         chk("R4", {29'd0, core_ncomp}, 32'(n));
      end
      rd_chk("R5", 32'hC, 32'd0);

      // R5: start a three-component frame
      access(1'b0, 32'h0, 32'h7, 4'hF);
      chk("R5", {29'd0, o_st1, o_st2, o_st3}, 32'd2);
      rd_chk("R4", 32'h0, 32'h6);
      rd_chk("R5", 32'hC, 32'd1);

      // R9: start bit without lane 0 is dropped
      access(1'b0, 32'h0, 32'h3, 4'hE);
      chk("R9", {29'd0, o_st1, o_st2, o_st3}, 32'd0);
      rd_chk("R9", 32'h0, 32'h6);

      // R6: done moves busy to done, then sticks
      pulse_done();
      rd_chk("R6", 32'hC, 32'd2);
      pulse_done();
      rd_chk("R6", 32'hC, 32'd2);

      // R5: control write without start keeps done
      access(1'b0, 32'h0, 32'h2, 4'hF);
      rd_chk("R5", 32'hC, 32'd2);
      // R5: new start returns to busy
      access(1'b0, 32'h0, 32'h3, 4'hF);
      chk("R5", {29'd0, o_st1, o_st2, o_st3}, 32'd2);
      rd_chk("R5", 32'hC, 32'd1);
      chk("R4", {29'd0, core_ncomp}, 32'd1);
      pulse_done();
      rd_chk("R6", 32'hC, 32'd2);

      @(negedge clk);
      chk("R3", bus_rdata, 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

endmodule